// File: doc/BRIEF.md
# 24-bit reloading countdown timer

This block is a periodic interval timer that sits in a small window of an expansion board's address space and is reached over a byte-wide register bus. Software programs a 24-bit reload value through three byte registers and sets the enable bit in a control register. Writing the control register with the enable bit set copies the reload value into the counter. From then on the counter steps down by one in every clock cycle in which the prescaled `tick` input is high.

When the count runs out, the block raises a sticky zero-detect flag, refills the counter from the reload value and keeps counting. It never stops by itself. The interrupt line follows the flag. Software acknowledges the event by writing anything to the flag's register, which drops the interrupt. A read-only jumper port in the same window always reads as zero. Every register in the window can be read back, apart from the counter itself.

The bus is a single-cycle strobe interface: `bus_en` with `bus_we` high is a write, and `bus_en` with `bus_we` low is a read. Read data is combinational and valid in the same cycle as the strobe.

Top module: `tick24_timer`

## Requirements
- R1: Only offsets from 0xA000 to 0xA200 inclusive belong to the block. A write outside that range changes no register, and a read outside it returns 0x00.
- R2: The register index is offset bits [8:4]. Bits [3:0] are ignored, so offset 0xA135 addresses the same register as 0xA130.
- R3: Index 0x10 is the control register. Bit 0 enables counting, and the whole written byte reads back unchanged.
- R4: A control write with bit 0 set loads the counter from the reload value at that clock edge. This restarts a running period, and the load wins over a tick in the same cycle.
- R5: Indexes 0x13, 0x14 and 0x15 hold the reload value's bits [23:16], [15:8] and [7:0], and each reads back what was written. Writing them does not disturb the count in progress; the new value takes effect at the next refill.
- R6: In each cycle with `tick` high and counting enabled, a count above 1 decreases by 1. A count of 1 or 0 instead sets the zero-detect flag and refills from the reload value. A reload value of N ≥ 1 therefore gives a period of N ticks, and a reload value of 0 gives an event on every tick.
- R7: `irq` is high exactly while the zero-detect flag is set.
- R8: A read of index 0x1A returns the flag in bit 0, with zeros above it. Any write to index 0x1A clears the flag. If a zero event occurs in the same cycle as such a write, the flag stays set.
- R9: A read of the jumper port, index 0x0C, returns 0x00. So does a read of any index in the window that has no register.
- R10: After reset, the control byte, the reload bytes, the counter and the flag are all zero, and `irq` is low.
- R11: While the enable bit is clear, ticks neither change the counter nor raise the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_en | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Board offset of the access |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data byte (combinational, 0x00 when not reading the window) |
| tick | input | 1 | Prescaled count tick; decrements once per high cycle |
| irq | output | 1 | Interrupt, high while zero-detect is set |

## Verification
The bench checks the exact tick on which the interrupt rises, for reload values of 3, 0 and 0x010000. A design that counts down to zero and only then reloads would be one tick late. A design that swaps the byte order would wait 1 tick instead of 65536. A restart by control write in mid-period, and a reload write in mid-period, are each timed, which exposes a design that ignores the restart or applies the new reload at once. The bench clears the flag in the same cycle as a zero event, so a design that gives the clear priority loses the event. It also issues writes just outside the window with index bits that alias real registers, which catches a decoder that tests only the index.

// File: rtl/tick24_pkg.sv
package tick24_pkg;
  localparam int IDX_W = 5;
  typedef logic [IDX_W-1:0] reg_idx_t;

  localparam reg_idx_t IDX_JUMPER = 5'h0C;
  localparam reg_idx_t IDX_CTRL   = 5'h10;
  localparam reg_idx_t IDX_PRE_HI = 5'h13;  // hi, mid, lo follow in order
  localparam reg_idx_t IDX_STAT   = 5'h1A;
endpackage

// File: rtl/tick24_decode.sv
module tick24_decode
  import tick24_pkg::*;
#(
  parameter int                ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] WIN_LO  = 16'hA000,
  parameter logic [ADDR_W-1:0] WIN_HI  = 16'hA200,
  parameter int                IDX_LSB = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              in_win_o,
  output reg_idx_t          idx_o
);
  always_comb begin
    in_win_o = (addr_i >= WIN_LO) && (addr_i <= WIN_HI);
    idx_o    = addr_i[IDX_LSB +: IDX_W];
  end
endmodule

// File: rtl/tick24_regs.sv
module tick24_regs
  import tick24_pkg::*;
#(
  parameter int CNT_W = 24,
  localparam int NBYTES = CNT_W / 8
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             wr_stb_i,
  input  logic             rd_stb_i,
  input  reg_idx_t         idx_i,
  input  logic [7:0]       wdata_i,
  input  logic             status_i,
  output logic             enable_o,
  output logic             load_o,
  output logic             clr_o,
  output logic [CNT_W-1:0] preload_o,
  output logic [7:0]       rdata_o
);
  logic [7:0] ctrl_q, ctrl_d;
  logic [7:0] pre_q [NBYTES];
  logic       wr_ctrl;

  always_comb begin
    wr_ctrl = wr_stb_i && (idx_i == IDX_CTRL);
    ctrl_d  = wr_ctrl ? wdata_i : ctrl_q;
    load_o  = wr_ctrl && wdata_i[0];
    clr_o   = wr_stb_i && (idx_i == IDX_STAT);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else         ctrl_q <= ctrl_d;
  end

  assign enable_o = ctrl_q[0];

  for (genvar g = 0; g < NBYTES; g++) begin : g_pre
    logic       wr_g;
    logic [7:0] pre_d;
    always_comb begin
      wr_g  = wr_stb_i && (idx_i == IDX_PRE_HI + IDX_W'(g));
      pre_d = wr_g ? wdata_i : pre_q[g];
    end
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) pre_q[g] <= '0;
      else         pre_q[g] <= pre_d;
    end
    assign preload_o[CNT_W-1-8*g -: 8] = pre_q[g];
  end

  always_comb begin
    rdata_o = '0;
    if (rd_stb_i) begin
      if (idx_i == IDX_CTRL) rdata_o = ctrl_q;
      if (idx_i == IDX_STAT) rdata_o = {7'b0, status_i};
      for (int i = 0; i < NBYTES; i++)
        if (idx_i == IDX_PRE_HI + IDX_W'(i)) rdata_o = pre_q[i];
    end
  end

  // R4: only a control write with bit 0 set may restart the counter
  p_load_only_on_ctrl_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    load_o |-> (wr_stb_i && idx_i == IDX_CTRL));
endmodule

// File: rtl/tick24_core.sv
module tick24_core #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             enable_i,
  input  logic             load_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] preload_i,
  output logic             status_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             status_q, status_d;
  logic             run_tick, zero_hit;

  always_comb begin
    run_tick = tick_i && enable_i && !load_i;
    zero_hit = run_tick && (cnt_q <= CNT_W'(1));
    cnt_d    = cnt_q;
    if (load_i)        cnt_d = preload_i;
    else if (zero_hit) cnt_d = preload_i;
    else if (run_tick) cnt_d = cnt_q - CNT_W'(1);
    status_d = status_q;
    if (zero_hit)   status_d = 1'b1;
    else if (clr_i) status_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      status_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      status_q <= status_d;
    end
  end

  assign status_o = status_q;

  p_load_copies_preload_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(preload_i)));
  p_step_down_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (tick_i && enable_i && !load_i && cnt_q > CNT_W'(1)) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
  p_zero_refill_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (tick_i && enable_i && !load_i && cnt_q <= CNT_W'(1)) |=> (status_q && cnt_q == $past(preload_i)));
  p_clear_drops_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (clr_i && !(tick_i && enable_i && !load_i && cnt_q <= CNT_W'(1))) |=> !status_q);
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    (!load_i && !(tick_i && enable_i)) |=> ($stable(cnt_q) && (status_q || !$past(status_q) || $past(clr_i))));
endmodule

// File: rtl/tick24_timer.sv
module tick24_timer
  import tick24_pkg::*;
#(
  parameter int                ADDR_W = 16,
  parameter int                CNT_W  = 24,
  parameter logic [ADDR_W-1:0] WIN_LO = 16'hA000,
  parameter logic [ADDR_W-1:0] WIN_HI = 16'hA200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              tick,
  output logic              irq
);
  logic [1:0]       rst_sync_q;
  logic             rst_ni;
  logic             in_win, wr_stb, rd_stb;
  reg_idx_t         idx;
  logic             enable, load, clr, status;
  logic [CNT_W-1:0] preload;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  tick24_decode #(.ADDR_W(ADDR_W), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI), .IDX_LSB(4)) u_dec (
    .addr_i(bus_addr), .in_win_o(in_win), .idx_o(idx));

  assign wr_stb = bus_en && bus_we && in_win;
  assign rd_stb = bus_en && !bus_we && in_win;

  tick24_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_ni(rst_ni), .wr_stb_i(wr_stb), .rd_stb_i(rd_stb), .idx_i(idx),
    .wdata_i(bus_wdata), .status_i(status), .enable_o(enable), .load_o(load),
    .clr_o(clr), .preload_o(preload), .rdata_o(bus_rdata));

  tick24_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_ni(rst_ni), .tick_i(tick), .enable_i(enable), .load_i(load),
    .clr_i(clr), .preload_i(preload), .status_o(status));

  assign irq = status;

  p_outside_reads_zero_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_en && !bus_we && (bus_addr < WIN_LO || bus_addr > WIN_HI)) |-> (bus_rdata == 8'h00));
  p_reset_quiet_r10: assert property (@(posedge clk)
    (!rst_ni) |-> !irq);
endmodule

// File: tb/tick24_timer_test.sv
`timescale 1ns/1ps
module tick24_timer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_en = 1'b0, bus_we = 1'b0, tick = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        irq;
  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  tick24_timer uut (.clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick(tick), .irq(irq));

  // {write, offset, data, expected read}
  localparam int NV = 17;
  localparam logic [32:0] VEC [NV] = '{
    {1'b1, 16'hA130, 8'h12, 8'h00},  // R5 hi byte
    {1'b1, 16'hA140, 8'h34, 8'h00},  // R5 mid byte
    {1'b1, 16'hA150, 8'h56, 8'h00},  // R5 lo byte
    {1'b0, 16'hA130, 8'h00, 8'h12},  // R5
    {1'b0, 16'hA140, 8'h00, 8'h34},  // R5
    {1'b0, 16'hA150, 8'h00, 8'h56},  // R5
    {1'b0, 16'hA135, 8'h00, 8'h12},  // R2 low nibble ignored
    {1'b0, 16'hA0C0, 8'h00, 8'h00},  // R9 jumper port
    {1'b0, 16'hA1A0, 8'h00, 8'h00},  // R8 flag clear
    {1'b0, 16'hA000, 8'h00, 8'h00},  // R9 unused index
    {1'b1, 16'h9130, 8'hFF, 8'h00},  // R1 below window, aliases 0x13
    {1'b0, 16'hA130, 8'h00, 8'h12},  // R1 untouched
    {1'b1, 16'hA330, 8'hFF, 8'h00},  // R1 above window, aliases 0x13
    {1'b0, 16'hA130, 8'h00, 8'h12},  // R1 untouched
    {1'b0, 16'h9130, 8'h00, 8'h00},  // R1 outside read
    {1'b1, 16'hA100, 8'h06, 8'h00},  // R3 control, bit 0 clear
    {1'b0, 16'hA100, 8'h00, 8'h06}   // R3 readback
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      tick = 1'b1;
    end
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic set_pre(input logic [23:0] v);
    wr(16'hA130, v[23:16]);
    wr(16'hA140, v[15:8]);
    wr(16'hA150, v[7:0]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all) actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    chk("R10 irq", irq, 0);
    rd(16'hA100, r); chk("R10 ctrl", r, 0);
    rd(16'hA130, r); chk("R10 pre hi", r, 0);
    rd(16'hA150, r); chk("R10 pre lo", r, 0);
    rd(16'hA1A0, r); chk("R10 flag", r, 0);

    // table walk: R1 R2 R3 R5 R8 R9
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][32]) wr(VEC[i][31:16], VEC[i][15:8]);
      else begin
        rd(VEC[i][31:16], r);
        chk($sformatf("table[%0d] R1/R2/R3/R5/R8/R9", i), r, VEC[i][7:0]);
      end
    end

    // R6 R7 period of 3, with reload
    set_pre(24'h000003);
    wr(16'hA100, 8'h01);
    ticks(2); chk("R6 before 3rd tick", irq, 0);
    ticks(1); chk("R7 irq at 3rd tick", irq, 1);
    rd(16'hA1A0, r); chk("R8 flag read", r, 8'h01);
    wr(16'hA1A0, 8'h00); chk("R8 clear drops irq", irq, 0);
    rd(16'hA1A0, r); chk("R8 flag after clear", r, 8'h00);
    ticks(2); chk("R6 reload period early", irq, 0);
    ticks(1); chk("R6 reload period", irq, 1);
    wr(16'hA1A0, 8'h5A);

    // R4 restart mid-period
    set_pre(24'h000005);
    wr(16'hA100, 8'h01);
    ticks(3);
    wr(16'hA100, 8'h01);
    ticks(4); chk("R4 restart not yet", irq, 0);
    ticks(1); chk("R4 restart full period", irq, 1);
    wr(16'hA1A0, 8'h00);

    // R5 reload write mid-period
    set_pre(24'h000004);
    wr(16'hA100, 8'h01);
    ticks(1);
    wr(16'hA150, 8'h0A);
    ticks(2); chk("R5 old count runs", irq, 0);
    ticks(1); chk("R5 old count ends", irq, 1);
    wr(16'hA1A0, 8'h00);
    ticks(9); chk("R5 new value early", irq, 0);
    ticks(1); chk("R5 new value used", irq, 1);
    wr(16'hA1A0, 8'h00);

    // R6 reload value zero: event every tick
    set_pre(24'h000000);
    wr(16'hA100, 8'h01);
    chk("R6 zero no tick yet", irq, 0);
    ticks(1); chk("R6 zero first tick", irq, 1);
    wr(16'hA1A0, 8'h00);
    ticks(1); chk("R6 zero every tick", irq, 1);
    wr(16'hA1A0, 8'h00);

    // R11 disabled counter ignores ticks
    set_pre(24'h000002);
    wr(16'hA100, 8'h01);
    ticks(1);
    wr(16'hA100, 8'h00);
    ticks(5); chk("R11 disabled no event", irq, 0);
    rd(16'hA100, r); chk("R11 ctrl off", r, 8'h00);

    // R8 event and clear in the same cycle
    wr(16'hA100, 8'h01);
    ticks(1);
    @(negedge clk);
    tick = 1'b1; bus_en = 1'b1; bus_we = 1'b1; bus_addr = 16'hA1A0; bus_wdata = 8'h00;
    @(negedge clk);
    tick = 1'b0; bus_en = 1'b0; bus_we = 1'b0;
    chk("R8 event beats clear", irq, 1);
    wr(16'hA1A0, 8'h00); chk("R8 later clear", irq, 0);

    // R5 R6 byte order: 0x010000 ticks
    set_pre(24'h010000);
    wr(16'hA100, 8'h01);
    ticks(65535); chk("R5 hi byte weight early", irq, 0);
    ticks(1);     chk("R5 hi byte weight", irq, 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule